// File: doc/BRIEF.md
# Two-Level Prioritised Interrupt Controller

This block gathers 32 interrupt requests and presents them to one processor core on two lines: a critical line and a noncritical line. Requests 0 to 12 come from outside the chip and are synchronised first. Requests 13 to 31 are on-chip and are used as they arrive. For each request, software chooses three things: edge or level sensing, the active polarity, and which of the two lines it drives.

Edge requests are latched into a status word and stay there until software clears them by writing 1 to the bit. Level requests show their live state after the polarity is applied. An enable word masks the status word. Among the enabled critical requests, a priority encoder picks one winner. The winner's index is scaled and added to a programmable base, which gives the vector the core fetches to dispatch straight to the right handler. The search direction can be reversed with one control bit.

All control and status is reached through a plain register port. A write is one cycle with `reg_wr` high. Reads are combinational from `reg_addr`.

Top module: `irq_ctl_top`

## Requirements
- R1: After reset, these all read 0: status, enable, masked status, trigger, route, order and base. Polarity reads all ones (active high). Both interrupt lines are low and the vector reads 0.
- R2: A source with its trigger bit at 1 (edge) sets its status bit on the clock edge after its polarity-corrected value goes from 0 to 1. The bit stays set after the input goes inactive.
- R3: A polarity bit of 0 makes the source active low. An edge source then latches on a falling input, and a level source is active while the input is low.
- R4: A source with its trigger bit at 0 (level) has a status bit equal to its corrected input. Writing 1 to that bit in the status register has no effect.
- R5: Writing 1 to a latched edge bit at status address 0 clears it, and writing 0 leaves it set. If a new active edge arrives on the same clock edge as the clearing write, the bit stays set.
- R6: Sources 0 to 12 pass through two flops before detection. An edge appears in status after the third clock edge following the input change. A level change appears after the second edge. Sources 13 to 31 latch on the first edge.
- R7: Masked status (address 2) is status AND enable (address 1). `crit_irq` is the OR of the masked bits whose route bit (address 5) is 1. `ncrit_irq` is the OR of the masked bits whose route bit is 0.
- R8: With order bit 0 (address 6) at 0, the lowest-numbered pending critical source wins. At 1, the highest-numbered one wins.
- R9: `crit_vec` and address 8 give base (address 7) plus winner index × 512. They give the base when no critical request is pending.
- R10: Register map: 0 status, 1 enable, 2 masked status (read only), 3 polarity (1 = active high), 4 trigger (1 = edge), 5 route (1 = critical), 6 order, 7 vector base, 8 vector (read only). Written values read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 32 | Raw interrupt requests; bits 0-12 external, 13-31 internal |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| crit_irq | output | 1 | Critical interrupt line |
| ncrit_irq | output | 1 | Noncritical interrupt line |
| crit_vec | output | 32 | Vector for the winning critical source |

## Verification
Two events can land on the same clock edge: a software clear of a latched edge bit, and a fresh active edge on that same source. The bench provokes this by driving the write-1-to-clear and the rising input together. It then reads status and expects the bit still set. A second clear, made while the input is held steady, must drop the bit. The same kind of overlap is tested for priority: a latched edge source and a live level source are both critical and pending together. The vector is checked in both order settings.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int NUM_SRC   = 32;
  localparam int NUM_EXT   = 13;
  localparam int ADDR_W    = 4;
  localparam int VEC_SHIFT = 9;

  typedef enum logic [ADDR_W-1:0] {
    RA_STAT  = 4'd0,
    RA_ENAB  = 4'd1,
    RA_MASK  = 4'd2,
    RA_POL   = 4'd3,
    RA_TRIG  = 4'd4,
    RA_ROUTE = 4'd5,
    RA_ORDER = 4'd6,
    RA_BASE  = 4'd7,
    RA_VEC   = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int N   = 32,
  parameter int EXT = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] synced
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i < EXT) begin : g_ext
      logic s1_q, s2_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          s1_q <= 1'b0;
          s2_q <= 1'b0;
        end else begin
          s1_q <= raw[i];
          s2_q <= s1_q;
        end
      end
      assign synced[i] = s2_q;
    end else begin : g_int
      assign synced[i] = raw[i];
    end
  end

  // Warm-up count so the two-cycle look-back never reaches before reset
  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (!rst_n) warm_q <= 2'd0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  assert_sync_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= 2'd2) |-> (synced[EXT-1:0] == $past(raw[EXT-1:0], 2)));
endmodule

// File: rtl/irq_detect.sv
module irq_detect #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] clr,
  output logic [N-1:0] stat
);
  logic [N-1:0] act, prev_q, edge_q, rise;

  assign act  = lvl ^ ~pol;
  assign rise = act & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      edge_q <= '0;
    end else begin
      prev_q <= act;
      edge_q <= ((edge_q & ~clr) | rise) & trig;
    end
  end

  assign stat = (edge_q & trig) | (act & ~trig);

  // A latched bit may only appear where an active edge was seen
  assert_set_by_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_q & ~$past(edge_q)) & ~$past(rise & trig)) == '0);

  // A latched bit may only vanish under a clear write or a mode change
  assert_hold_until_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(edge_q) & ~edge_q & $past(trig) & ~$past(clr)) == '0);
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     pend,
  input  logic             rev,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    if (rev) begin
      for (int i = 0; i < N; i++)
        if (pend[i]) idx = IDX_W'(i);
    end else begin
      for (int i = N - 1; i >= 0; i--)
        if (pend[i]) idx = IDX_W'(i);
    end
  end

  assign any = |pend;

  assert_winner_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> pend[idx]);

  assert_winner_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (rev ? (((pend >> idx) >> 1) == '0)
                 : ((pend & ((N'(1) << idx) - N'(1))) == '0)));
endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
  import irq_ctl_pkg::*;
#(
  parameter int N     = NUM_SRC,
  parameter int EXT   = NUM_EXT,
  parameter int AW    = ADDR_W,
  parameter int VSH   = VEC_SHIFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_in,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [N-1:0]  reg_wdata,
  output logic [N-1:0]  reg_rdata,
  output logic          crit_irq,
  output logic          ncrit_irq,
  output logic [N-1:0]  crit_vec
);
  localparam int IDX_W = $clog2(N);

  logic [N-1:0] enab_q, pol_q, trig_q, route_q, base_q;
  logic         order_q;
  logic [N-1:0] synced, stat, masked, clr, crit_pend;
  logic         crit_any;
  logic [IDX_W-1:0] win_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enab_q  <= '0;
      pol_q   <= '1;
      trig_q  <= '0;
      route_q <= '0;
      base_q  <= '0;
      order_q <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_ENAB:  enab_q  <= reg_wdata;
        RA_POL:   pol_q   <= reg_wdata;
        RA_TRIG:  trig_q  <= reg_wdata;
        RA_ROUTE: route_q <= reg_wdata;
        RA_BASE:  base_q  <= reg_wdata;
        RA_ORDER: order_q <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  assign clr = (reg_wr && reg_addr == RA_STAT) ? reg_wdata : '0;

  irq_sync #(.N(N), .EXT(EXT)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(src_in), .synced(synced)
  );

  irq_detect #(.N(N)) u_detect (
    .clk(clk), .rst_n(rst_n), .lvl(synced), .pol(pol_q),
    .trig(trig_q), .clr(clr), .stat(stat)
  );

  assign masked    = stat & enab_q;
  assign crit_pend = masked & route_q;

  irq_prio #(.N(N), .IDX_W(IDX_W)) u_prio (
    .clk(clk), .rst_n(rst_n), .pend(crit_pend), .rev(order_q),
    .any(crit_any), .idx(win_idx)
  );

  assign crit_irq  = crit_any;
  assign ncrit_irq = |(masked & ~route_q);
  assign crit_vec  = crit_any ? (base_q + (N'(win_idx) << VSH)) : base_q;

  always_comb begin
    case (reg_addr)
      RA_STAT:  reg_rdata = stat;
      RA_ENAB:  reg_rdata = enab_q;
      RA_MASK:  reg_rdata = masked;
      RA_POL:   reg_rdata = pol_q;
      RA_TRIG:  reg_rdata = trig_q;
      RA_ROUTE: reg_rdata = route_q;
      RA_ORDER: reg_rdata = {{(N-1){1'b0}}, order_q};
      RA_BASE:  reg_rdata = base_q;
      RA_VEC:   reg_rdata = crit_vec;
      default:  reg_rdata = '0;
    endcase
  end

  assert_vec_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !crit_irq |-> (crit_vec == base_q));

  assert_lines_cover_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (crit_irq || ncrit_irq) == (masked != '0));
endmodule

// File: tb/test_irq_ctl_top.sv
module test_irq_ctl_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_in = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        crit_irq, ncrit_irq;
  logic [31:0] crit_vec;

  always #2.5 clk = ~clk;

  irq_ctl_top i_irq_ctl_top (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .crit_irq(crit_irq), .ncrit_irq(ncrit_irq), .crit_vec(crit_vec)
  );

  typedef struct {
    int          kind;   // 0 rdata, 1 crit, 2 ncrit, 3 vec
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [31:0] IDLE = (32'd1 << 17) | (32'd1 << 21);
  localparam logic [31:0] VB   = 32'h0010_0000;
  localparam logic [31:0] POLV = ~IDLE;
  localparam logic [31:0] TRGV = (32'd1 << 3) | (32'd1 << 20) | (32'd1 << 21) | (32'd1 << 22);
  localparam logic [31:0] RTEV = (32'd1 << 3) | (32'd1 << 16) | (32'd1 << 20);

  // monitor: pops one expected item per falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = reg_rdata;
        1: act = {31'd0, crit_irq};
        2: act = {31'd0, ncrit_irq};
        default: act = crit_vec;
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic chk(input int kind, input logic [3:0] addr,
                     input logic [31:0] exp, input string tag);
    item_t it;
    @(posedge clk); #1;
    reg_addr = addr;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] addr, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = addr; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic set_src(input logic [31:0] v);
    @(posedge clk); #1;
    src_in = v;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk(0, 4'd0, 32'h0, "R1 status");
    chk(0, 4'd3, 32'hFFFF_FFFF, "R1 polarity");
    chk(0, 4'd4, 32'h0, "R1 trigger");
    chk(3, 4'd0, 32'h0, "R1 vector");
    chk(1, 4'd0, 32'h0, "R1 crit");
    chk(2, 4'd0, 32'h0, "R1 ncrit");

    set_src(IDLE);
    wr(4'd3, POLV); wr(4'd4, TRGV); wr(4'd5, RTEV);
    wr(4'd1, 32'hFFFF_FFFF); wr(4'd7, VB);
    chk(0, 4'd3, POLV, "R10 polarity readback");
    chk(0, 4'd5, RTEV, "R10 route readback");
    chk(0, 4'd7, VB, "R10 base readback");
    chk(0, 4'd0, 32'h0, "R10 status idle");

    // R2 internal edge latch
    set_src(IDLE | (32'd1 << 20));
    chk(0, 4'd0, 32'd1 << 20, "R2 latched");
    chk(1, 4'd0, 32'd1, "R7 crit line");
    chk(3, 4'd0, VB + 32'h2800, "R9 vector src20");
    set_src(IDLE);
    chk(0, 4'd0, 32'd1 << 20, "R2 held");

    // R5 clearing
    wr(4'd0, 32'h0);
    chk(0, 4'd0, 32'd1 << 20, "R5 write0 no effect");
    wr(4'd0, 32'd1 << 20);
    chk(0, 4'd0, 32'h0, "R5 cleared");
    chk(1, 4'd0, 32'd0, "R7 crit low");
    chk(0, 4'd8, VB, "R9 vector idle");

    // R3 active-low edge
    set_src(IDLE & ~(32'd1 << 21));
    chk(0, 4'd0, 32'd1 << 21, "R3 falling latched");
    chk(2, 4'd0, 32'd1, "R7 ncrit line");
    chk(1, 4'd0, 32'd0, "R7 crit stays low");
    set_src(IDLE);
    chk(0, 4'd0, 32'd1 << 21, "R3 held");
    wr(4'd0, 32'd1 << 21);
    chk(0, 4'd0, 32'h0, "R3 cleared");

    // R4 level sources
    set_src(IDLE | (32'd1 << 16));
    chk(0, 4'd0, 32'd1 << 16, "R4 level high");
    chk(3, 4'd0, VB + 32'h2000, "R9 vector src16");
    wr(4'd0, 32'd1 << 16);
    chk(0, 4'd0, 32'd1 << 16, "R4 clear ignored");
    set_src(IDLE);
    chk(0, 4'd0, 32'h0, "R4 level follows");
    set_src(IDLE & ~(32'd1 << 17));
    chk(0, 4'd0, 32'd1 << 17, "R3 active-low level");
    chk(2, 4'd0, 32'd1, "R7 ncrit level");
    set_src(IDLE);
    chk(0, 4'd0, 32'h0, "R4 active-low released");

    // R7 masking
    wr(4'd1, ~(32'd1 << 16));
    set_src(IDLE | (32'd1 << 16));
    chk(0, 4'd0, 32'd1 << 16, "R7 raw status");
    chk(0, 4'd2, 32'h0, "R7 masked off");
    chk(1, 4'd0, 32'd0, "R7 crit masked");
    wr(4'd1, 32'hFFFF_FFFF);
    chk(0, 4'd2, 32'd1 << 16, "R7 masked on");
    chk(1, 4'd0, 32'd1, "R7 crit unmasked");

    // R8 priority with two pending critical sources
    set_src(IDLE | (32'd1 << 16) | (32'd1 << 20));
    set_src(IDLE | (32'd1 << 16));
    chk(3, 4'd0, VB + 32'h2000, "R8 forward winner 16");
    wr(4'd6, 32'd1);
    chk(0, 4'd6, 32'd1, "R10 order readback");
    chk(0, 4'd8, VB + 32'h2800, "R8 reverse winner 20");
    wr(4'd6, 32'd0);
    set_src(IDLE);
    wr(4'd0, 32'd1 << 20);
    chk(0, 4'd0, 32'h0, "R8 cleanup");

    // R6 external synchroniser latency
    set_src(IDLE | (32'd1 << 3));
    chk(0, 4'd0, 32'h0, "R6 edge after 1");
    chk(0, 4'd0, 32'h0, "R6 edge after 2");
    chk(0, 4'd0, 32'd1 << 3, "R6 edge after 3");
    set_src(IDLE);
    repeat (4) @(posedge clk);
    wr(4'd0, 32'd1 << 3);
    set_src(IDLE | (32'd1 << 5));
    chk(0, 4'd0, 32'h0, "R6 level after 1");
    chk(0, 4'd0, 32'd1 << 5, "R6 level after 2");
    set_src(IDLE);
    repeat (4) @(posedge clk);
    chk(0, 4'd0, 32'h0, "R6 level released");

    // R5 clear and new edge on the same clock edge
    set_src(IDLE | (32'd1 << 22));
    set_src(IDLE);
    chk(0, 4'd0, 32'd1 << 22, "R5 pulse latched");
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'd1 << 22;
    src_in = IDLE | (32'd1 << 22);
    @(posedge clk); #1;
    reg_wr = 1'b0;
    chk(0, 4'd0, 32'd1 << 22, "R5 set wins over clear");
    wr(4'd0, 32'd1 << 22);
    chk(0, 4'd0, 32'h0, "R5 steady input cleared");
    set_src(IDLE);

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule